// File: doc/BRIEF.md
# Multi-word NCO carrier generator

This block is a numerically controlled oscillator that synthesizes a digital carrier and mixes two baseband channels onto it. Three 24-bit frequency words sit in byte-wide registers that a host fills over an 8-bit write bus. A 2-bit select input picks one of the words, or a zero-frequency setting. The selected word reaches the phase accumulator only when a load event occurs. A load event is a rising edge of the load pulse or of the data-enable input. Because of this, the select pins and the registers can be changed freely ahead of a burst, and the new carrier then starts at a known instant.

Each clock, the phase accumulator advances by the active increment. Its top bits address a compact parabolic sine/cosine approximation. The in-phase input is multiplied by the cosine and the quadrature input by the sine. Each product can have its sign inverted. The combined sum is scaled, saturated to 12 bits and registered. It leaves the block either in two's complement or in offset binary.

Top module: `nco_carrier_gen`

## Requirements
- R1: While `rst_n` is low, `phase` and `sample` read 0. The three frequency words, the active increment and the control register all clear to 0.
- R2: Each clock with reset released, `phase` advances by the active step modulo 2^24. The carrier frequency is therefore fCLK × step / 2^24.
- R3: The active increment is updated only on a load event: a clock where `load` is high after being low on the previous clock, or where `den_in` is high after being low on the previous clock. Changing `sel` or any register without a load event leaves the phase step unchanged.
- R4: On a load event, `sel` = 00, 01 and 10 transfer word A, B and C respectively. `sel` = 11 transfers zero, so `phase` holds its current value.
- R5: A register write happens on a clock where `wr_n` is high after being low on the previous clock and `cs_n` is low. Bytes 0x00–0x02 hold word A, 0x03–0x05 word B and 0x06–0x08 word C, least significant byte at the lowest address. A write strobe with `cs_n` high changes nothing.
- R6: Address 0x20 is the control register. Bit 0 inverts the I product, bit 1 inverts the Q product, bit 2 selects two's complement output (0 = offset binary), and bit 3 complements the step. Writes to any other address above 0x08 are ignored.
- R7: The combined value is I·cos+Q·sin, −I·cos+Q·sin, I·cos−Q·sin or −I·cos−Q·sin for sign bits [1:0] = 00, 01, 10 and 11.
- R8: Let a = phase[23:16] and x = a mod 128. Then sin(a) = x·(128−x), negated when a ≥ 128, and cos(a) = sin((a+64) mod 256).
- R9: The signed sum is arithmetically shifted right by 8 bits and then saturated to the range −2048..+2047.
- R10: In two's complement mode, `sample` is the saturated value. In offset binary mode, `sample` is the saturated value with its MSB inverted.
- R11: When control bit 3 is set, the accumulator adds the bitwise complement of the active increment.
- R12: `sample` is registered. Its value after a clock edge is computed from the `phase`, control register, `i_in` and `q_in` values present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; the write commits on its rising edge |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data byte |
| sel | input | 2 | Frequency word select |
| load | input | 1 | Load pulse; a rising edge transfers the selected word |
| den_in | input | 1 | Data enable; a rising edge also transfers the selected word |
| i_in | input | 8 | In-phase sample, signed |
| q_in | input | 8 | Quadrature sample, signed |
| phase | output | 24 | Phase accumulator value |
| sample | output | 12 | Combined carrier sample |

## Verification
The bench builds the block with its default parameters: 24-bit phase, 8-bit table index, 8-bit I/Q and a shift of 8. With these values, full-scale I and Q inputs push the shifted sum past ±2047, so saturation can be reached. The large frequency words chosen by the bench wrap the 24-bit accumulator within a few cycles, so every octant of the wave table is visited. All four sign codes, both output formats and the complemented step are run with several I/Q patterns.

// File: rtl/nco_carrier_gen.sv
module nco_carrier_gen #(
  parameter int PHASE_W   = 24,
  parameter int LUT_W     = 8,
  parameter int IQ_W      = 8,
  parameter int OUT_W     = 12,
  parameter int OUT_SHIFT = 8,
  parameter int ADDR_W    = 6,
  parameter int CTRL_ADDR = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   wr_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  input  logic [1:0]             sel,
  input  logic                   load,
  input  logic                   den_in,
  input  logic signed [IQ_W-1:0] i_in,
  input  logic signed [IQ_W-1:0] q_in,
  output logic [PHASE_W-1:0]     phase,
  output logic [OUT_W-1:0]       sample
);
  localparam int NWORD  = 3;
  localparam int BYTES  = (PHASE_W + 7) / 8;
  localparam int NREG   = NWORD * BYTES;
  localparam int HALF   = 1 << (LUT_W - 1);
  localparam int QUART  = 1 << (LUT_W - 2);
  localparam int SIN_W  = 2 * LUT_W - 2;
  localparam int PROD_W = IQ_W + SIN_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

  logic [NREG*8-1:0]  regs;
  logic [3:0]         ctrl;
  logic [PHASE_W-1:0] incr, acc, step, word;
  logic               wr_q, ld_q, den_q, wr_evt, load_evt;

  assign wr_evt   = wr_n & ~wr_q & ~cs_n;
  assign load_evt = (load & ~ld_q) | (den_in & ~den_q);
  assign step     = ctrl[3] ? ~incr : incr;
  assign phase    = acc;

  always_comb begin
    word = '0;
    for (int k = 0; k < NWORD; k++)
      if (sel == 2'(k)) word = regs[k*BYTES*8 +: PHASE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0; ctrl <= '0; incr <= '0; acc <= '0;
      wr_q <= 1'b0; ld_q <= 1'b0; den_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      ld_q  <= load;
      den_q <= den_in;
      acc   <= acc + step;
      if (load_evt) incr <= word;
      if (wr_evt) begin
        for (int k = 0; k < NREG; k++)
          if (addr == ADDR_W'(k)) regs[k*8 +: 8] <= wdata;
        if (addr == ADDR_W'(CTRL_ADDR)) ctrl <= wdata[3:0];
      end
    end
  end

  function automatic logic signed [SIN_W-1:0] wave(input logic [LUT_W-1:0] a);
    logic [SIN_W-1:0] xx, m;
    xx = SIN_W'(a[LUT_W-2:0]);
    m  = xx * (SIN_W'(HALF) - xx);
    return a[LUT_W-1] ? -$signed(m) : $signed(m);
  endfunction

  logic [LUT_W-1:0]         s_idx;
  logic signed [SIN_W-1:0]  sin_v, cos_v;
  logic signed [PROD_W-1:0] p_i, p_q;
  logic signed [SUM_W-1:0]  sum, scaled;
  logic [OUT_W-1:0]         sat;

  assign s_idx  = acc[PHASE_W-1 -: LUT_W];
  assign sin_v  = wave(s_idx);
  assign cos_v  = wave(s_idx + LUT_W'(QUART));
  assign p_i    = PROD_W'(i_in) * PROD_W'(cos_v);
  assign p_q    = PROD_W'(q_in) * PROD_W'(sin_v);
  assign sum    = (ctrl[0] ? -SUM_W'(p_i) : SUM_W'(p_i)) + (ctrl[1] ? -SUM_W'(p_q) : SUM_W'(p_q));
  assign scaled = sum >>> OUT_SHIFT;
  assign sat    = (scaled > HI) ? HI[OUT_W-1:0] : (scaled < LO) ? LO[OUT_W-1:0] : scaled[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample <= '0;
    else        sample <= ctrl[2] ? sat : {~sat[OUT_W-1], sat[OUT_W-2:0]};
  end

  // R3
  incr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(incr));
  // R4
  zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && sel == 2'b11) |=> incr == '0);
  // R4
  phase_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incr == '0 && !ctrl[3]) |=> $stable(phase));
  // R5
  no_select_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(regs) && $stable(ctrl)));
endmodule

// File: tb/sim_nco_carrier_gen.sv
`timescale 1ns/1ps
module sim_nco_carrier_gen;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, load = 1'b0, den_in = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] sel = '0;
  logic signed [7:0] i_in = '0, q_in = '0;
  logic [23:0] phase;
  logic [11:0] sample;
  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  nco_carrier_gen u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .sel(sel), .load(load), .den_in(den_in), .i_in(i_in), .q_in(q_in),
    .phase(phase), .sample(sample));

  logic [7:0]  m_regs [9];
  logic [3:0]  m_ctrl;
  logic [23:0] m_incr, m_acc;
  logic [11:0] m_smp;
  logic        m_wrq, m_ldq, m_denq;
  logic [23:0] q_ph [$];
  logic [11:0] q_sm [$];

  function automatic int bsin(int a);
    int x = a % 128;
    int m = x * (128 - x);
    return (a >= 128) ? -m : m;
  endfunction

  function automatic logic [11:0] ref_sample(logic [23:0] ph, int iv, int qv, logic [3:0] c);
    int a = int'(ph[23:16]);
    int pi = iv * bsin((a + 64) % 256);
    int pq = qv * bsin(a);
    int s, t;
    if (c[0]) pi = -pi;
    if (c[1]) pq = -pq;
    s = (pi + pq) >>> 8;
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    t = c[2] ? s : s + 2048;
    return t[11:0];
  endfunction

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      foreach (m_regs[k]) m_regs[k] = '0;
      m_ctrl = '0; m_incr = '0; m_acc = '0; m_smp = '0;
      m_wrq = 0; m_ldq = 0; m_denq = 0;
    end else begin
      logic [23:0] stp, sw;
      stp   = m_ctrl[3] ? ~m_incr : m_incr;
      m_smp = ref_sample(m_acc, int'(i_in), int'(q_in), m_ctrl);
      m_acc = m_acc + stp;
      if ((load && !m_ldq) || (den_in && !m_denq)) begin
        sw = (sel == 2'b11) ? 24'h0 :
             {m_regs[sel*3+2], m_regs[sel*3+1], m_regs[sel*3]};
        m_incr = sw;
      end
      if (wr_n && !m_wrq && !cs_n) begin
        if (addr < 9) m_regs[addr] = wdata;
        else if (addr == 6'h20) m_ctrl = wdata[3:0];
      end
      m_wrq = wr_n; m_ldq = load; m_denq = den_in;
      q_ph.push_back(m_acc);
      q_sm.push_back(m_smp);
    end
  end

  always @(negedge clk) begin
    if (q_ph.size() > 0) begin
      logic [23:0] eph;
      logic [11:0] esm;
      eph = q_ph.pop_front();
      esm = q_sm.pop_front();
      checks++;
      if (phase !== eph || sample !== esm) begin
        errors++;
        $display("FAIL %s: phase=%h sample=%h expected phase=%h sample=%h",
                 cur_req, phase, sample, eph, esm);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk); addr = a; wdata = d; cs_n = sel_n; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic wr_word(input int w, input logic [23:0] v);
    for (int b = 0; b < 3; b++) wr(6'(w*3 + b), v[b*8 +: 8], 1'b0);
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic run(input int n, input int iv, input int qv, input int di, input int dq);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      i_in = 8'(iv + k*di);
      q_in = 8'(qv + k*dq);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (phase !== 24'h0 || sample !== 12'h0) begin
      errors++;
      $display("FAIL R1: phase=%h sample=%h expected 000000 000", phase, sample);
    end
    rst_n = 1;
    cur_req = "R5 write layout";
    wr_word(0, 24'h123456);
    wr_word(1, 24'h0A0B0C);
    wr_word(2, 24'h7FF001);
    cur_req = "R3 no load yet";
    run(10, 50, -30, 3, 5);
    cur_req = "R2 R8 R12 word A";
    sel = 0; pulse_load();
    run(60, -120, 90, 4, -3);
    cur_req = "R3 sel change without load";
    sel = 2; run(20, 10, 10, 1, 1);
    cur_req = "R4 word C via load";
    pulse_load(); run(40, 127, -128, -5, 6);
    cur_req = "R3 den_in edge word B";
    sel = 1; @(negedge clk); den_in = 1; run(30, 60, 60, 0, 0);
    den_in = 0;
    cur_req = "R4 zero select freeze";
    sel = 3; pulse_load(); run(20, 100, -100, 0, 0);
    cur_req = "R5 write with cs high ignored";
    wr(6'h00, 8'hFF, 1'b1); wr(6'h20, 8'h0F, 1'b1);
    sel = 0; pulse_load(); run(30, 40, 40, 2, 2);
    cur_req = "R6 unmapped address ignored";
    wr(6'h15, 8'h0F, 1'b0); run(10, 70, 20, 0, 0);
    for (int c = 0; c < 8; c++) begin
      cur_req = (c < 4) ? "R7 R10 offset binary signs" : "R7 R10 twos complement signs";
      wr(6'h20, 8'(c), 1'b0);
      run(40, 90, -70, 1, 2);
    end
    cur_req = "R9 saturation";
    run(60, -128, -128, 0, 0);
    run(60, 127, -128, 0, 0);
    cur_req = "R11 complemented step";
    wr(6'h20, 8'h0C, 1'b0);
    sel = 1; pulse_load(); run(40, -60, 33, 1, -1);
    cur_req = "R11 complement with zero word";
    sel = 3; pulse_load(); run(20, 20, 20, 0, 0);
    cur_req = "R1 reset again";
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    checks++;
    if (phase !== 24'h0 || sample !== 12'h0) begin
      errors++;
      $display("FAIL R1: phase=%h sample=%h expected 000000 000", phase, sample);
    end
    rst_n = 1;
    cur_req = "R1 cleared words";
    sel = 2; pulse_load(); run(10, 5, 5, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule